// File: doc/BRIEF.md
# Two-Bank Interrupt Controller

This block gathers 64 interrupt lines into two banks of 32 sources. It raises a single request line towards one processor. Each source is fixed at build time as either edge-latched or level-sensitive. An edge-latched source records a pending event on the rising edge of its synchronized input, and the event stays recorded until software clears it. A level-sensitive source never records an event. It requests service only while its input is high and its enable bit is set.

Software reaches the block through a plain 32-bit register port inside a 4 KiB window. A write strobe captures data on the clock edge, and read data follows the address combinationally. Each bank has four word locations: pending events, enable mask, write-one-to-clear, and live input levels. The inputs are numbered in reverse bank order: the upper 32 inputs feed the first bank. A build option swaps the byte lanes on both the write path and the read path, for big-endian hosts.

Top module: `irq_two_bank_ctrl`

## Requirements
- R1: After reset, the pending, mask and level registers of both banks read as zero, and `cpu_irq` is low.
- R2: Input n drives bank 1 − (n/32), bit n mod 32. The first bank is at base 0x10 and the second at base 0x20, and live levels read at base + 0xC. So input 0 appears as bit 0 at 0x2C, and input 63 appears as bit 31 at 0x1C.
- R3: The rising edge of an edge-latched input sets its pending bit, which reads at base + 0x0. The bit stays set after the input falls.
- R4: The level-sensitive sets are 0x00000000 for the first bank and 0x1FF00000 for the second (bits 20 to 28). A level-sensitive source never sets its pending bit. It requests service exactly while its input is high and its mask bit is set. Bits 19 and 29 of the second bank are edge-latched.
- R5: A write to base + 0x8 clears the pending bits where the data is 1 and leaves the bits where it is 0. The write has no effect on a level-sensitive request.
- R6: The mask is written and read back at base + 0x4. `cpu_irq` is the OR, over both banks, of (pending | (level & level-sensitive set)) & mask.
- R7: `cpu_irq` is registered. It changes on the clock edge after the edge that updated the mask or pending state.
- R8: An address whose bank index ((addr − 0x10) >> 4, modulo 4096) is 2 or more reads as zero. Writes to such an address change nothing.
- R9: Reads of offset 0x8, and of any offset other than 0x0, 0x4 and 0xC, return zero.
- R10: With `BIG_ENDIAN` set, byte k of the bus data maps to byte 3 − k of the internal registers, on both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt source lines, asynchronous |
| bus_addr | input | 12 | Byte address inside the register window |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds two instances side by side on the same bus and inputs. The first uses the default parameters: little-endian lanes, two synchronizer stages, and level-sensitive sets 0 and 0x1FF00000. The second differs only in having `BIG_ENDIAN` set. In the first instance the edges of the level-sensitive range (bits 19, 20, 28 and 29) come within reach, along with the interaction between clear writes and level requests. Comparing the two instances shows the lane swap at the ports: a mask value enables a source only after its bytes are reversed, and a pending bit reads back in the mirrored byte.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register offsets inside one bank (decoded by software, so fixed)
  localparam logic [3:0] OFF_PEND = 4'h0;
  localparam logic [3:0] OFF_MASK = 4'h4;
  localparam logic [3:0] OFF_CLR  = 4'h8;
  localparam logic [3:0] OFF_LVL  = 4'hC;
  // Byte offset of the first bank inside the window
  localparam int unsigned BANK_BASE = 16;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned         WIDTH   = 32,
  parameter logic [WIDTH-1:0]    LVL_SET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_lvl,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             req_o
);
  logic [WIDTH-1:0] pend_q, pend_d;
  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] rise, clr_eff;

  // next-state
  always_comb begin
    rise    = src_lvl & ~lvl_q;
    clr_eff = clr_we ? (wdata & ~LVL_SET) : '0;
    // a new edge in the same cycle as a clear wins
    pend_d  = (pend_q & ~clr_eff) | (rise & ~LVL_SET);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      lvl_q  <= '0;
    end else begin
      pend_q <= pend_d;
      lvl_q  <= src_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  assign req_o  = |((pend_q | (lvl_q & LVL_SET)) & mask_q);
  assign pend_o = pend_q;
  assign lvl_o  = lvl_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_two_bank_ctrl.sv
module irq_two_bank_ctrl #(
  parameter int unsigned      BANK_W      = 32,
  parameter int unsigned      ADDR_W      = 12,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter bit               BIG_ENDIAN  = 1'b0,
  parameter logic [BANK_W-1:0] LVL_SET_A  = '0,
  parameter logic [BANK_W-1:0] LVL_SET_B  = 32'h1FF0_0000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [irqc_pkg::NUM_BANKS*BANK_W-1:0] irq_in,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic                             bus_wr,
  input  logic [BANK_W-1:0]                bus_wdata,
  output logic [BANK_W-1:0]                bus_rdata,
  output logic                             cpu_irq
);
  import irqc_pkg::*;

  localparam int unsigned NB     = NUM_BANKS;
  localparam int unsigned NUM_IN = NB * BANK_W;
  localparam int unsigned NBYTES = BANK_W / 8;
  localparam int unsigned IDX_W  = ADDR_W - 4;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // input synchronizer
  logic [NUM_IN-1:0] irq_sync;
  irqc_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(irq_in), .dout(irq_sync)
  );

  // byte lanes
  logic [BANK_W-1:0] wd_sw, rd_raw;
  if (BIG_ENDIAN) begin : g_swap
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      assign wd_sw[8*k +: 8]     = bus_wdata[8*(NBYTES-1-k) +: 8];
      assign bus_rdata[8*k +: 8] = rd_raw[8*(NBYTES-1-k) +: 8];
    end
  end else begin : g_noswap
    assign wd_sw     = bus_wdata;
    assign bus_rdata = rd_raw;
  end

  // address decode
  logic [ADDR_W-1:0] rel_addr;
  logic [IDX_W-1:0]  bank_idx;
  logic [3:0]        off;
  logic [NB-1:0]     sel_b;
  assign rel_addr = bus_addr - ADDR_W'(BANK_BASE);
  assign bank_idx = rel_addr[ADDR_W-1:4];
  assign off      = bus_addr[3:0];

  logic [NB-1:0][BANK_W-1:0] pend_b, lvl_b, mask_b;
  logic [NB-1:0]             req_b;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [BANK_W-1:0] CFG = (b == 0) ? LVL_SET_A : LVL_SET_B;
    assign sel_b[b] = (bank_idx == IDX_W'(b));
    irqc_bank #(.WIDTH(BANK_W), .LVL_SET(CFG)) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .src_lvl (irq_sync[(NB-1-b)*BANK_W +: BANK_W]),
      .mask_we (bus_wr && sel_b[b] && (off == OFF_MASK)),
      .clr_we  (bus_wr && sel_b[b] && (off == OFF_CLR)),
      .wdata   (wd_sw),
      .pend_o  (pend_b[b]),
      .lvl_o   (lvl_b[b]),
      .mask_o  (mask_b[b]),
      .req_o   (req_b[b])
    );
  end

  // read mux
  always_comb begin
    rd_raw = '0;
    for (int b = 0; b < NB; b++) begin
      if (sel_b[b]) begin
        case (off)
          OFF_PEND: rd_raw = pend_b[b];
          OFF_MASK: rd_raw = mask_b[b];
          OFF_LVL:  rd_raw = lvl_b[b];
          default:  rd_raw = '0;
        endcase
      end
    end
  end

  // registered request
  logic irq_d, irq_q;
  assign irq_d = |req_b;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end
  assign cpu_irq = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned       BANK_W    = 32,
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [BANK_W-1:0] LVL_SET_A = '0,
  parameter logic [BANK_W-1:0] LVL_SET_B = 32'h1FF0_0000
) (
  input logic                  clk,
  input logic                  rst_int_n,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [BANK_W-1:0]     wd_sw,
  input logic [2*BANK_W-1:0]   pend_all,
  input logic [2*BANK_W-1:0]   lvl_all,
  input logic [2*BANK_W-1:0]   mask_all,
  input logic                  cpu_irq
);
  localparam logic [2*BANK_W-1:0] LVL_ALL = {LVL_SET_B, LVL_SET_A};

  logic [ADDR_W-1:0] rel;
  logic              bad_bank, mask_wr_a;
  logic              req_now;
  assign rel       = bus_addr - ADDR_W'(16);
  assign bad_bank  = (rel[ADDR_W-1:4] > 1);
  assign mask_wr_a = bus_wr && (rel[ADDR_W-1:4] == 0) && (bus_addr[3:0] == 4'h4);
  assign req_now   = |((pend_all | (lvl_all & LVL_ALL)) & mask_all);

  // R4: level-sensitive sources never hold a pending bit
  p_lvl_no_pend_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pend_all & LVL_ALL) == '0);

  // R7: request follows the bank state one edge later
  p_irq_registered_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (cpu_irq == $past(req_now)));

  // R3: without a bus write, pending bits are never lost
  p_pend_sticky_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_wr |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

  // R8: a write outside the two banks leaves masks and pending bits alone
  p_bad_bank_ignored_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bad_bank) |=> ($stable(mask_all) &&
      ((pend_all & $past(pend_all)) == $past(pend_all))));

  // R6: a mask write to the first bank lands as written
  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mask_wr_a |=> (mask_all[BANK_W-1:0] == $past(wd_sw)));
endmodule

bind irq_two_bank_ctrl irqc_checker #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LVL_SET_A(LVL_SET_A), .LVL_SET_B(LVL_SET_B)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_sw(wd_sw), .pend_all(pend_b), .lvl_all(lvl_b), .mask_all(mask_b),
  .cpu_irq(cpu_irq)
);

// File: tb/irq_two_bank_ctrl_tb.sv
module irq_two_bank_ctrl_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_be;
  logic        irq, irq_be;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_two_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .cpu_irq(irq)
  );

  irq_two_bank_ctrl #(.BIG_ENDIAN(1'b1)) u_dut_be (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_be), .cpu_irq(irq_be)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] d_be);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = rdata; d_be = rdata_be;
  endtask

  task automatic settle(); repeat (6) @(negedge clk); endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_in[n] = 1'b1;
    repeat (4) @(negedge clk); irq_in[n] = 1'b0;
    settle();
  endtask

  task automatic clean();
    irq_in = '0;
    settle();
    wr(12'h014, 32'h0); wr(12'h024, 32'h0);
    wr(12'h018, 32'hFFFF_FFFF); wr(12'h028, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d, db;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 be irq after reset", {31'b0, irq_be}, 32'h0);
    foreach (d[i]) begin end
    for (int a = 0; a < 2; a++) begin
      rd(12'(16 + 16*a), d, db);      chk("R1 pending zero", d, 32'h0);
      rd(12'(16 + 16*a + 4), d, db);  chk("R1 mask zero", d, 32'h0);
      rd(12'(16 + 16*a + 12), d, db); chk("R1 level zero", d, 32'h0);
    end
  endtask

  task automatic t_mapping();
    logic [31:0] d, db;
    clean();
    @(negedge clk); irq_in[0] = 1'b1;
    settle();
    rd(12'h02C, d, db); chk("R2 input0 -> bank2 bit0", d, 32'h1);
    rd(12'h01C, d, db); chk("R2 input0 not in bank1", d, 32'h0);
    @(negedge clk); irq_in[63] = 1'b1; irq_in[40] = 1'b1;
    settle();
    rd(12'h01C, d, db); chk("R2 inputs 63,40 -> bank1", d, 32'h8000_0100);
    @(negedge clk); irq_in = '0;
    settle();
    rd(12'h01C, d, db); chk("R2 levels fall", d, 32'h0);
    rd(12'h010, d, db); chk("R3 bank1 pending sticky", d, 32'h8000_0100);
    rd(12'h020, d, db); chk("R3 bank2 pending sticky", d, 32'h1);
    chk("R6 masked pending gives no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d, db;
    wr(12'h018, 32'h8000_0000);
    rd(12'h010, d, db); chk("R5 clear one bit", d, 32'h0000_0100);
    wr(12'h018, 32'h0);
    rd(12'h010, d, db); chk("R5 zero data clears nothing", d, 32'h0000_0100);
    wr(12'h028, 32'hFFFF_FFFF);
    rd(12'h020, d, db); chk("R5 clear all bank2", d, 32'h0);
    rd(12'h010, d, db); chk("R5 bank2 clear spares bank1", d, 32'h0000_0100);
    wr(12'h018, 32'h0000_0100);
    rd(12'h010, d, db); chk("R5 clear last bit", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d, db;
    clean();
    @(negedge clk); irq_in[20] = 1'b1;
    settle();
    rd(12'h020, d, db); chk("R4 level source not pending", d, 32'h0);
    rd(12'h02C, d, db); chk("R4 level visible", d, 32'h0010_0000);
    chk("R4 unmasked level no irq", {31'b0, irq}, 32'h0);
    wr(12'h024, 32'h0010_0000);
    chk("R7 irq not yet after mask write", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq one edge later", {31'b0, irq}, 32'h1);
    wr(12'h028, 32'hFFFF_FFFF);
    settle();
    chk("R5 clear leaves level request", {31'b0, irq}, 32'h1);
    rd(12'h024, d, db); chk("R6 mask readback", d, 32'h0010_0000);
    @(negedge clk); irq_in[20] = 1'b0;
    settle();
    chk("R4 level request drops with input", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_boundary();
    logic [31:0] d, db;
    clean();
    pulse(19); pulse(20); pulse(28); pulse(29);
    rd(12'h020, d, db); chk("R4 edges of level range", d, 32'h2008_0000);
  endtask

  task automatic t_edge_irq();
    clean();
    pulse(32);
    chk("R6 pending but masked", {31'b0, irq}, 32'h0);
    wr(12'h014, 32'h1);
    @(negedge clk);
    chk("R3 edge event raises irq", {31'b0, irq}, 32'h1);
    wr(12'h018, 32'h1);
    @(negedge clk);
    chk("R5 clear drops irq", {31'b0, irq}, 32'h0);
    pulse(5);
    wr(12'h024, 32'h0000_0020);
    @(negedge clk);
    chk("R6 second bank feeds OR", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d, db;
    clean();
    wr(12'h014, 32'h0000_A5A5);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'hFF4, 32'hFFFF_FFFF);
    rd(12'h014, d, db); chk("R8 bank1 mask untouched", d, 32'h0000_A5A5);
    rd(12'h024, d, db); chk("R8 bank2 mask untouched", d, 32'h0);
    rd(12'h034, d, db); chk("R8 index2 reads zero", d, 32'h0);
    rd(12'h004, d, db); chk("R8 below base reads zero", d, 32'h0);
    pulse(32);
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h010, d, db); chk("R8 bad clear ignored", d, 32'h1);
    rd(12'h018, d, db); chk("R9 clear port reads zero", d, 32'h0);
    rd(12'h011, d, db); chk("R9 undefined offset reads zero", d, 32'h0);
    rd(12'h015, d, db); chk("R9 undefined offset near mask", d, 32'h0);
  endtask

  task automatic t_big_endian();
    logic [31:0] d, db;
    clean();
    wr(12'h014, 32'h0100_0000);
    pulse(32);
    chk("R10 le mask bit24 does not enable input32", {31'b0, irq}, 32'h0);
    chk("R10 be mask swapped enables input32", {31'b0, irq_be}, 32'h1);
    rd(12'h010, d, db);
    chk("R10 le pending", d, 32'h0000_0001);
    chk("R10 be pending swapped", db, 32'h0100_0000);
    rd(12'h014, d, db);
    chk("R10 be mask round trip", db, 32'h0100_0000);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mapping();
    t_clear();
    t_level();
    t_boundary();
    t_edge_irq();
    t_bad_addr();
    t_big_endian();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule